// File: doc/BRIEF.md
# Adaptive Sine/Cosine Noise Canceller Core

This core removes a periodic disturbance from a stream of signed fixed-point samples. It models the disturbance as a blend of one sine reference and one cosine reference. Each reference is scaled by its own adaptive weight, and the sum of the two scaled references is the running estimate. For each sample, the core first subtracts a caller-supplied offset from the incoming datum. It then subtracts the estimate, and the result is the residual error. The error trains both weights with a least-mean-squares rule whose step size is an input. A phase index walks through a 64-point reference table, one point per sample.

Arithmetic is signed 16-bit with 8 fraction bits (Q8.8). Each sample occupies the core for two clock cycles. A bank of three multipliers and three adders is time-shared between these two cycles. The first cycle applies the weight correction earned by the previous sample's error. The second cycle forms the new estimate and the new error. The host offers a sample with a valid strobe while the core reports ready. A one-cycle done pulse then marks the moment the estimate and the error are refreshed.

Top module: `afc_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the estimate, the error, both weights, the stored previous references and the phase index to zero. It also drops done and raises sampleReady.
- R2: sampleReady is high exactly when the core is idle. A sample is accepted at a rising edge where sampleValid and sampleReady are both high. sampleReady is then low for the next two cycles, and sampleValid has no effect while sampleReady is low.
- R3: estOut and errOut change only together, at the second rising edge after the accepting edge. done is high for exactly the one cycle that follows that edge.
- R4: The estimate is sat(sat(rnd(w1·s)) + sat(rnd(w2·c))). Here s and c are the sine and cosine entries at the current phase. rnd(p) is (p + 128) arithmetically shifted right by 8, which rounds half upward.
- R5: The error is sat(sat(datum − offset) − estimate). It uses the datum and offset of the same sample.
- R6: Before forming the estimate of a sample, each weight is updated as w ← sat(w + sat(rnd(g·r))). Here g = sat((mu·e + 64) >>> 7) is twice mu times the previous sample's error e, and r is the reference that the previous sample used with that weight. The previous error and references are zero after reset.
- R7: Reference table entry k (0..63) is round(256·sin(2πk/64)), rounded half away from zero. The sine for phase p is entry p, and the cosine is entry (p + 16) mod 64.
- R8: The phase index starts at 0 after reset, advances by one per accepted sample, and wraps from 63 to 0.
- R9: Every sum, difference and rounded product saturates to the range −32768..32767 instead of wrapping.
- R10: datumIn, offsetIn and muIn are sampled at the falling clock edge inside the accepting cycle. Later changes to them do not affect that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the inputs are captured on its falling edge and all other state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | A new sample is offered |
| sampleReady | output | 1 | The core is idle and can take a sample |
| datumIn | input | 16 | Raw input sample, signed Q8.8 |
| offsetIn | input | 16 | Offset removed from the sample, signed Q8.8 |
| muIn | input | 16 | Adaptation step size, signed Q8.8 |
| estOut | output | 16 | Disturbance estimate, signed Q8.8 |
| errOut | output | 16 | Residual error, signed Q8.8 |
| done | output | 1 | One-cycle pulse when estOut and errOut are refreshed |

## Verification
The embedded properties assume that reset is applied before the first sample. They also assume that sampleValid and the three data inputs are settled by the falling edge of any cycle in which they are offered. The stimulus changes every input one nanosecond after a rising edge, so each value is stable over both the falling edge that latches it and the next rising edge. Some stimulus deliberately alters the data inputs and holds sampleValid high during the two busy cycles, to show that this traffic is ignored. One run pushes the weights and the error into saturation with an extreme step size and a full-scale input.

// File: rtl/afc_pkg.sv
package afc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UPD  = 2'd1,
    ST_EST  = 2'd2
  } afcStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch datum, offset and mu on the falling edge
    logic stepUpd;   // cycle 1: weight correction and offset removal
    logic stepEst;   // cycle 2: estimate, error and phase advance
  } afcStrobeT;

endpackage

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleValid,
  output logic      sampleReady,
  output logic      done,
  output afcStrobeT strobe
);

  afcStateT stateQ;
  logic     accept;
  logic     doneQ;

  assign accept      = (stateQ == ST_IDLE) && sampleValid;
  assign sampleReady = (stateQ == ST_IDLE);
  assign done        = doneQ;

  always_comb begin
    strobe         = '0;
    strobe.capture = accept;
    strobe.stepUpd = (stateQ == ST_UPD);
    strobe.stepEst = (stateQ == ST_EST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= (stateQ == ST_EST);
      case (stateQ)
        ST_IDLE: if (sampleValid) stateQ <= ST_UPD;
        ST_UPD:  stateQ <= ST_EST;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !sampleReady); // R2
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##3 done); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3

endmodule

// File: rtl/afc_sincos_rom.sv
module afc_sincos_rom #(
  parameter int DataW  = 16,
  parameter int PhaseW = 6
) (
  input  logic [PhaseW-1:0]       idx,
  output logic signed [DataW-1:0] val
);

  localparam int Quarter = 2 ** (PhaseW - 2);

  // one quarter wave of sin scaled by 256, entries 0..16
  function automatic logic signed [DataW-1:0] quarterWave(input logic [PhaseW-2:0] m);
    case (m)
      0:  return DataW'(0);
      1:  return DataW'(25);
      2:  return DataW'(50);
      3:  return DataW'(74);
      4:  return DataW'(98);
      5:  return DataW'(121);
      6:  return DataW'(142);
      7:  return DataW'(162);
      8:  return DataW'(181);
      9:  return DataW'(198);
      10: return DataW'(213);
      11: return DataW'(226);
      12: return DataW'(237);
      13: return DataW'(245);
      14: return DataW'(251);
      15: return DataW'(255);
      default: return DataW'(256);
    endcase
  endfunction

  logic [1:0]              quadrant;
  logic [PhaseW-2:0]       fold;
  logic signed [DataW-1:0] mag;

  assign quadrant = idx[PhaseW-1:PhaseW-2];

  always_comb begin
    if (quadrant[0]) fold = (PhaseW-1)'(Quarter) - {1'b0, idx[PhaseW-3:0]};
    else             fold = {1'b0, idx[PhaseW-3:0]};
    mag = quarterWave(fold);
    val = quadrant[1] ? -mag : mag;
  end

endmodule

// File: rtl/afc_datapath.sv
module afc_datapath
  import afc_pkg::*;
#(
  parameter int DataW  = 16,
  parameter int FracW  = 8,
  parameter int PhaseW = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  afcStrobeT               strobe,
  input  logic signed [DataW-1:0] datumIn,
  input  logic signed [DataW-1:0] offsetIn,
  input  logic signed [DataW-1:0] muIn,
  output logic signed [DataW-1:0] estOut,
  output logic signed [DataW-1:0] errOut
);

  localparam int ProdW   = 2 * DataW;
  localparam int Quarter = 2 ** (PhaseW - 2);
  localparam logic signed [ProdW:0] HiLim = $signed({{(ProdW-DataW+2){1'b0}}, {(DataW-1){1'b1}}});
  localparam logic signed [ProdW:0] LoLim = ~HiLim;
  localparam logic signed [DataW-1:0] MaxV = {1'b0, {(DataW-1){1'b1}}};
  localparam logic signed [DataW-1:0] MinV = {1'b1, {(DataW-1){1'b0}}};

  function automatic logic signed [DataW-1:0] clampWide(input logic signed [ProdW:0] v);
    if (v > HiLim)      return MaxV;
    else if (v < LoLim) return MinV;
    else                return v[DataW-1:0];
  endfunction

  function automatic logic signed [DataW-1:0] mulRnd(
    input logic signed [DataW-1:0] a,
    input logic signed [DataW-1:0] b,
    input int                      sh
  );
    logic signed [ProdW-1:0] p;
    logic signed [ProdW:0]   t;
    p = ProdW'(a) * ProdW'(b);
    t = $signed({p[ProdW-1], p}) + $signed((ProdW+1)'(64'd1 << (sh - 1)));
    return clampWide(t >>> sh);
  endfunction

  function automatic logic signed [DataW-1:0] addSubSat(
    input logic signed [DataW-1:0] x,
    input logic signed [DataW-1:0] y,
    input logic                    sub
  );
    logic signed [DataW:0] r;
    r = sub ? ($signed({x[DataW-1], x}) - $signed({y[DataW-1], y}))
            : ($signed({x[DataW-1], x}) + $signed({y[DataW-1], y}));
    if (r[DataW] != r[DataW-1]) return r[DataW] ? MinV : MaxV;
    return r[DataW-1:0];
  endfunction

  // falling-edge input capture
  logic signed [DataW-1:0] datumQ, offsetQ, muQ;
  always_ff @(negedge clk) begin
    if (rst) begin
      datumQ  <= '0;
      offsetQ <= '0;
      muQ     <= '0;
    end else if (strobe.capture) begin
      datumQ  <= datumIn;
      offsetQ <= offsetIn;
      muQ     <= muIn;
    end
  end

  // state
  logic [PhaseW-1:0]       phaseQ;
  logic signed [DataW-1:0] w1Q, w2Q, corrQ, outQ, errQ, sPrevQ, cPrevQ;

  // reference table, port 0 sine and port 1 cosine (quarter-turn ahead)
  logic signed [DataW-1:0] refVal [2];
  for (genvar i = 0; i < 2; i++) begin : g_ref
    localparam int Shift = i * Quarter;
    afc_sincos_rom #(.DataW(DataW), .PhaseW(PhaseW)) u_rom (
      .idx (phaseQ + PhaseW'(Shift)),
      .val (refVal[i])
    );
  end

  // shared arithmetic bank
  logic signed [DataW-1:0] gVal, corrVal;
  logic signed [DataW-1:0] m1a, m1b, m2a, m2b, p1, p2;
  logic signed [DataW-1:0] a0x, a0Res, a1x, a1y, a1Res;

  always_comb begin
    gVal    = mulRnd(muQ, errQ, FracW - 1);          // 2*mu*e
    corrVal = addSubSat(datumQ, offsetQ, 1'b1);
    m1a = strobe.stepUpd ? gVal   : w1Q;
    m1b = strobe.stepUpd ? sPrevQ : refVal[0];
    m2a = strobe.stepUpd ? gVal   : w2Q;
    m2b = strobe.stepUpd ? cPrevQ : refVal[1];
    p1  = mulRnd(m1a, m1b, FracW);
    p2  = mulRnd(m2a, m2b, FracW);
    a0x = strobe.stepUpd ? w1Q : p2;
    a0Res = addSubSat(a0x, p1, 1'b0);
    a1x = strobe.stepUpd ? w2Q : corrQ;
    a1y = strobe.stepUpd ? p2  : a0Res;
    a1Res = addSubSat(a1x, a1y, !strobe.stepUpd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
      w1Q    <= '0;
      w2Q    <= '0;
      corrQ  <= '0;
      outQ   <= '0;
      errQ   <= '0;
      sPrevQ <= '0;
      cPrevQ <= '0;
    end else if (strobe.stepUpd) begin
      w1Q   <= a0Res;
      w2Q   <= a1Res;
      corrQ <= corrVal;
    end else if (strobe.stepEst) begin
      outQ   <= a0Res;
      errQ   <= a1Res;
      sPrevQ <= refVal[0];
      cPrevQ <= refVal[1];
      phaseQ <= phaseQ + 1'b1;
    end
  end

  assign estOut = outQ;
  assign errOut = errQ;

  AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    strobe.stepEst |=> phaseQ == $past(phaseQ) + 1'b1); // R8
  AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.stepUpd |=> $stable(w1Q) && $stable(w2Q)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.stepEst |=> $stable(outQ) && $stable(errQ)); // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    !(strobe.stepUpd && strobe.stepEst)); // R2

endmodule

// File: rtl/afc_core.sv
module afc_core
  import afc_pkg::*;
#(
  parameter int DataW  = 16,
  parameter int FracW  = 8,
  parameter int PhaseW = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleValid,
  output logic                    sampleReady,
  input  logic signed [DataW-1:0] datumIn,
  input  logic signed [DataW-1:0] offsetIn,
  input  logic signed [DataW-1:0] muIn,
  output logic signed [DataW-1:0] estOut,
  output logic signed [DataW-1:0] errOut,
  output logic                    done
);

  afcStrobeT strobe;

  afc_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .done        (done),
    .strobe      (strobe)
  );

  afc_datapath #(.DataW(DataW), .FracW(FracW), .PhaseW(PhaseW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .datumIn  (datumIn),
    .offsetIn (offsetIn),
    .muIn     (muIn),
    .estOut   (estOut),
    .errOut   (errOut)
  );

endmodule

// File: tb/sim_afc_core.sv
`timescale 1ns/1ps
module sim_afc_core;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic signed [15:0] datumIn = '0, offsetIn = '0, muIn = '0;
  logic sampleReady, done;
  logic signed [15:0] estOut, errOut;

  always #4 clk = ~clk;   // 125 MHz

  afc_core u0 (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleReady(sampleReady),
    .datumIn(datumIn), .offsetIn(offsetIn), .muIn(muIn),
    .estOut(estOut), .errOut(errOut), .done(done)
  );

  int vectors = 0;
  int misses  = 0;
  bit checking = 0;

  // behavioural reference
  int     mState = 0;
  longint mW1 = 0, mW2 = 0, mCorr = 0, mEst = 0, mErr = 0, mSp = 0, mCp = 0;
  int     mPh = 0;
  bit     mDone = 0;
  longint lD = 0, lO = 0, lM = 0;

  function automatic longint sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rnd(longint p, int sh);
    return sat16((p + (longint'(1) << (sh - 1))) >>> sh);
  endfunction

  function automatic longint sinTab(int k);
    real r;
    r = 256.0 * $sin(2.0 * 3.14159265358979 * k / 64.0);
    if (r >= 0.0) return longint'($rtoi(r + 0.5));
    return -longint'($rtoi(-r + 0.5));
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      lD = 0; lO = 0; lM = 0;
    end else if (mState == 0 && sampleValid) begin
      lD = datumIn; lO = offsetIn; lM = muIn;   // R10 capture point
    end
  end

  always @(posedge clk) begin
    longint g, s, c;
    if (rst) begin
      mState = 0; mW1 = 0; mW2 = 0; mCorr = 0; mEst = 0; mErr = 0;
      mSp = 0; mCp = 0; mPh = 0; mDone = 0;
    end else begin
      mDone = 0;
      case (mState)
        0: if (sampleValid) mState = 1;
        1: begin
          g     = rnd(lM * mErr, 7);
          mW1   = sat16(mW1 + rnd(g * mSp, 8));
          mW2   = sat16(mW2 + rnd(g * mCp, 8));
          mCorr = sat16(lD - lO);
          mState = 2;
        end
        default: begin
          s    = sinTab(mPh);
          c    = sinTab((mPh + 16) % 64);
          mEst = sat16(rnd(mW1 * s, 8) + rnd(mW2 * c, 8));
          mErr = sat16(mCorr - mEst);
          mSp = s; mCp = c;
          mPh = (mPh + 1) % 64;
          mDone = 1;
          mState = 0;
        end
      endcase
    end
  end

  task automatic check(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #6;
    if (checking) begin
      check("R2 sampleReady", longint'(sampleReady), longint'(mState == 0));
      check("R3 done", longint'(done), longint'(mDone));
      check("R4 R6 R7 R8 R9 estOut", longint'(estOut), mEst);
      check("R5 R9 R10 errOut", longint'(errOut), mErr);
    end
  end

  // offer one sample, then scramble inputs while busy (R10)
  task automatic send(int d, int o, int m, int gap);
    while (!sampleReady) begin @(posedge clk); #1; end
    sampleValid = 1'b1;
    datumIn = 16'(d); offsetIn = 16'(o); muIn = 16'(m);
    @(posedge clk); #1;
    sampleValid = 1'b0;
    datumIn = 16'(d ^ 16'h5a5a); offsetIn = 16'(o + 999); muIn = 16'(m + 77);
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 8);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #5;
    // R1 reset state
    check("R1 estOut", longint'(estOut), 0);
    check("R1 errOut", longint'(errOut), 0);
    check("R1 done", longint'(done), 0);
    check("R1 sampleReady", longint'(sampleReady), 1);
    checking = 1;
    @(posedge clk); #1;

    // periodic disturbance on top of an offset, mu about 0.1; >64 samples wraps phase (R8)
    for (int k = 0; k < 90; k++) begin
      int d;
      d = 2560 + $rtoi(300.0 * $sin(2.0 * 3.14159265358979 * k / 64.0 + 0.7)) + (k % 5) * 7;
      send(d, 2560, 26, k % 3);
    end

    // sampleValid held high with data changing every cycle (R2, R10)
    sampleValid = 1'b1;
    for (int k = 0; k < 40; k++) begin
      datumIn = 16'(2560 + ((k * 97) % 400) - 200);
      offsetIn = 16'(2560);
      muIn = 16'(40);
      @(posedge clk); #1;
    end
    sampleValid = 1'b0;
    repeat (3) begin @(posedge clk); #1; end

    // saturation run (R9)
    for (int k = 0; k < 12; k++)
      send((k % 2) ? -32768 : 32767, (k % 2) ? 32767 : -32768, 32767, 1);

    // reset in the middle of activity returns to the cleared state (R1)
    send(3000, 100, 26, 0);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int k = 0; k < 5; k++) send(2600 + k * 30, 2560, 26, 0);

    repeat (6) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule